// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control sequencer for a processor datapath in which each instruction is split into several clock steps, with at most one major unit (the ALU, the memory or the register file) busy in any one step. It is a Moore state machine of ten states held in a 4-bit state register. Its only data input is the 6-bit opcode field of the instruction register. Its outputs are the datapath steering and write-enable lines: program-counter loads, memory read and write, instruction-register load, register-file write, and the selects for the ALU operands, the ALU mode, the memory address, the write-back source, the destination register and the next program counter.

Every instruction starts with a fetch step and a decode step. During decode the block also sets up the ALU to compute the branch target ahead of time. The opcode then picks one of five paths: load, store, register-register ALU, branch-if-equal or jump. Each path ends by returning to fetch. A jump or branch takes 3 cycles, an ALU operation or store takes 4, and a load takes 5. Decoding the ALU function field and the datapath itself sit outside this block.

Top module: `mc_seq_ctrl`

## Requirements
- R1: An active-high synchronous `rst` puts the sequencer into the fetch step at the next rising edge, even in the middle of an instruction.
- R2: In the fetch step `mem_rd`, `instr_load` and `pc_load` are 1, `alu_b_sel`=01, and every other output is 0 (`addr_sel_data`=0, `alu_a_sel`=0, `alu_mode`=00, `pc_src`=00). The next step is always decode.
- R3: In the decode step `alu_b_sel`=11, and all other outputs are 0 (`alu_a_sel`=0, `alu_mode`=00).
- R4: From decode, the opcode picks the next step. Opcode 100011 (load) and 101011 (store) go to address computation. Opcode 000000 (ALU operation) goes to execute. Opcode 000100 (branch-if-equal) goes to branch. Opcode 000010 (jump) goes to jump.
- R5: In the address step `alu_a_sel`=1 and `alu_b_sel`=10, and all other outputs are 0. Opcode 101011 then goes to memory write. Any other opcode goes to memory read.
- R6: A load continues with memory read (`mem_rd`=1, `addr_sel_data`=1, all else 0). It then does load write-back (`rf_wr`=1, `wb_sel_mem`=1, `rf_dst_sel`=0, all else 0) and then returns to fetch.
- R7: A store continues with memory write (`mem_wr`=1, `addr_sel_data`=1, all else 0) and then returns to fetch.
- R8: An ALU operation continues with execute (`alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=10, all else 0). It then does ALU write-back (`rf_wr`=1, `rf_dst_sel`=1, `wb_sel_mem`=0, all else 0) and then returns to fetch.
- R9: The branch step has `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=01, `pc_load_if_eq`=1 and `pc_src`=01, with all else 0, and then returns to fetch.
- R10: The jump step has `pc_load`=1 and `pc_src`=10, with all else 0, and then returns to fetch.
- R11: From fetch back to fetch, an instruction takes 5 cycles for a load, 4 for a store or ALU operation, and 3 for a branch or jump.
- R12: Any opcode other than the five listed in R4 makes decode return straight to fetch, so the instruction takes 2 cycles.
- R13: The outputs depend only on the current step. A change of `opcode` within a cycle never changes the outputs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the current instruction |
| pc_load | output | 1 | Unconditional program-counter load |
| pc_load_if_eq | output | 1 | Program-counter load when the ALU reports equality |
| addr_sel_data | output | 1 | Memory address from the ALU result register (1) or the program counter (0) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| instr_load | output | 1 | Instruction register load |
| wb_sel_mem | output | 1 | Register write data from the memory data register (1) or the ALU result (0) |
| pc_src | output | 2 | Next program counter source: 00 ALU output, 01 ALU result register, 10 jump target |
| alu_mode | output | 2 | ALU mode: 00 add, 01 subtract/compare, 10 by function field |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 sign-extended offset, 11 shifted offset |
| alu_a_sel | output | 1 | ALU A operand: register A (1) or program counter (0) |
| rf_wr | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Destination register from bits 15:11 (1) or bits 20:16 (0) |

## Verification
Each of the five legal opcodes is driven through its full path, and all sixteen control bits are compared in every step. This separates a wrong dispatch from decode, a wrong load/store split in the address step, a wrong field value within a step, and a wrong path length. Two undefined opcodes check that decode falls back to fetch. The opcode is also changed in the middle of a cycle, to show that the outputs ignore it and that only the value present at the clock edge picks the next step. A reset in the middle of a load checks that a started instruction is abandoned.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OP_W    = 6;
    localparam int STATE_W = 4;

    localparam logic [OP_W-1:0] OPC_ALU    = 6'b000000;
    localparam logic [OP_W-1:0] OPC_LOAD   = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE  = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BRANCH = 6'b000100;
    localparam logic [OP_W-1:0] OPC_JUMP   = 6'b000010;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_MEMRD  = 4'd3,
        ST_LDWB   = 4'd4,
        ST_MEMWR  = 4'd5,
        ST_EXEC   = 4'd6,
        ST_ALUWB  = 4'd7,
        ST_BRANCH = 4'd8,
        ST_JUMP   = 4'd9
    } step_e;

    typedef enum logic [2:0] {
        CLS_LOAD,
        CLS_STORE,
        CLS_ALU,
        CLS_BRANCH,
        CLS_JUMP,
        CLS_OTHER
    } opclass_e;

    typedef struct packed {
        logic       pc_load;
        logic       pc_load_if_eq;
        logic       addr_sel_data;
        logic       mem_rd;
        logic       mem_wr;
        logic       instr_load;
        logic       wb_sel_mem;
        logic [1:0] pc_src;
        logic [1:0] alu_mode;
        logic [1:0] alu_b_sel;
        logic       alu_a_sel;
        logic       rf_wr;
        logic       rf_dst_sel;
    } ctrl_t;

    function automatic opclass_e classify(input logic [OP_W-1:0] op);
        case (op)
            OPC_LOAD:   return CLS_LOAD;
            OPC_STORE:  return CLS_STORE;
            OPC_ALU:    return CLS_ALU;
            OPC_BRANCH: return CLS_BRANCH;
            OPC_JUMP:   return CLS_JUMP;
            default:    return CLS_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/ctrl_op_classify.sv
module ctrl_op_classify
    import mc_ctrl_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output opclass_e        op_class
);
    always_comb op_class = classify(opcode);
endmodule

// File: rtl/ctrl_next_state.sv
module ctrl_next_state
    import mc_ctrl_pkg::*;
(
    input  step_e    cur,
    input  opclass_e op_class,
    output step_e    nxt
);
    always_comb begin
        nxt = ST_FETCH;
        case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                case (op_class)
                    CLS_LOAD, CLS_STORE: nxt = ST_ADDR;
                    CLS_ALU:             nxt = ST_EXEC;
                    CLS_BRANCH:          nxt = ST_BRANCH;
                    CLS_JUMP:            nxt = ST_JUMP;
                    default:             nxt = ST_FETCH;
                endcase
            end
            ST_ADDR:   nxt = (op_class == CLS_STORE) ? ST_MEMWR : ST_MEMRD;
            ST_MEMRD:  nxt = ST_LDWB;
            ST_EXEC:   nxt = ST_ALUWB;
            default:   nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/ctrl_state_reg.sv
module ctrl_state_reg
    import mc_ctrl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  step_e nxt,
    output step_e cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= ST_FETCH;
        else     cur <= nxt;
    end
endmodule

// File: rtl/ctrl_out_decode.sv
module ctrl_out_decode
    import mc_ctrl_pkg::*;
(
    input  step_e cur,
    output ctrl_t ctl
);
    always_comb begin
        ctl = '0;
        case (cur)
            ST_FETCH: begin
                ctl.mem_rd     = 1'b1;
                ctl.instr_load = 1'b1;
                ctl.pc_load    = 1'b1;
                ctl.alu_b_sel  = 2'b01;
            end
            ST_DECODE: ctl.alu_b_sel = 2'b11;
            ST_ADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = 2'b10;
            end
            ST_MEMRD: begin
                ctl.mem_rd        = 1'b1;
                ctl.addr_sel_data = 1'b1;
            end
            ST_LDWB: begin
                ctl.rf_wr      = 1'b1;
                ctl.wb_sel_mem = 1'b1;
            end
            ST_MEMWR: begin
                ctl.mem_wr        = 1'b1;
                ctl.addr_sel_data = 1'b1;
            end
            ST_EXEC: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_mode  = 2'b10;
            end
            ST_ALUWB: begin
                ctl.rf_wr      = 1'b1;
                ctl.rf_dst_sel = 1'b1;
            end
            ST_BRANCH: begin
                ctl.alu_a_sel     = 1'b1;
                ctl.alu_mode      = 2'b01;
                ctl.pc_load_if_eq = 1'b1;
                ctl.pc_src        = 2'b01;
            end
            ST_JUMP: begin
                ctl.pc_load = 1'b1;
                ctl.pc_src  = 2'b10;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
    import mc_ctrl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output logic            pc_load,
    output logic            pc_load_if_eq,
    output logic            addr_sel_data,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            instr_load,
    output logic            wb_sel_mem,
    output logic [1:0]      pc_src,
    output logic [1:0]      alu_mode,
    output logic [1:0]      alu_b_sel,
    output logic            alu_a_sel,
    output logic            rf_wr,
    output logic            rf_dst_sel
);
    opclass_e op_class;
    step_e    cur_step;
    step_e    nxt_step;
    ctrl_t    ctl;

    ctrl_op_classify u_cls (.opcode(opcode), .op_class(op_class));
    ctrl_next_state  u_nxt (.cur(cur_step), .op_class(op_class), .nxt(nxt_step));
    ctrl_state_reg   u_reg (.clk(clk), .rst(rst), .nxt(nxt_step), .cur(cur_step));
    ctrl_out_decode  u_dec (.cur(cur_step), .ctl(ctl));

    assign pc_load       = ctl.pc_load;
    assign pc_load_if_eq = ctl.pc_load_if_eq;
    assign addr_sel_data = ctl.addr_sel_data;
    assign mem_rd        = ctl.mem_rd;
    assign mem_wr        = ctl.mem_wr;
    assign instr_load    = ctl.instr_load;
    assign wb_sel_mem    = ctl.wb_sel_mem;
    assign pc_src        = ctl.pc_src;
    assign alu_mode      = ctl.alu_mode;
    assign alu_b_sel     = ctl.alu_b_sel;
    assign alu_a_sel     = ctl.alu_a_sel;
    assign rf_wr         = ctl.rf_wr;
    assign rf_dst_sel    = ctl.rf_dst_sel;

    // R1: reset always lands in fetch
    a_r1_reset_to_fetch: assert property (@(posedge clk)
        rst |=> (instr_load && mem_rd && pc_load));

    // R2: fetch is always followed by decode
    a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
        instr_load |=> (alu_b_sel == 2'b11 && !instr_load));

    // R6 / R8: any register write step is the last one
    a_r6_wb_returns: assert property (@(posedge clk) disable iff (rst)
        rf_wr |=> instr_load);

    // R7: store write returns to fetch
    a_r7_store_returns: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> instr_load);

    // R9: branch returns to fetch
    a_r9_branch_returns: assert property (@(posedge clk) disable iff (rst)
        pc_load_if_eq |=> instr_load);

    // R12: undefined opcode in decode goes back to fetch
    a_r12_undefined_returns: assert property (@(posedge clk) disable iff (rst)
        (cur_step == ST_DECODE && op_class == CLS_OTHER) |=> (cur_step == ST_FETCH));

    // R6 / R7: memory is never read and written together
    a_r6_no_rd_wr_clash: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
endmodule

// File: tb/mc_seq_ctrl_tb_top.sv
module mc_seq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b0;
    logic pc_load, pc_load_if_eq, addr_sel_data, mem_rd, mem_wr, instr_load;
    logic wb_sel_mem, alu_a_sel, rf_wr, rf_dst_sel;
    logic [1:0] pc_src, alu_mode, alu_b_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mc_seq_ctrl dut_i (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_load(pc_load), .pc_load_if_eq(pc_load_if_eq),
        .addr_sel_data(addr_sel_data), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .instr_load(instr_load), .wb_sel_mem(wb_sel_mem), .pc_src(pc_src),
        .alu_mode(alu_mode), .alu_b_sel(alu_b_sel), .alu_a_sel(alu_a_sel),
        .rf_wr(rf_wr), .rf_dst_sel(rf_dst_sel)
    );

    // packed as {pc_load, pc_load_if_eq, addr_sel_data, mem_rd, mem_wr,
    // instr_load, wb_sel_mem, pc_src, alu_mode, alu_b_sel, alu_a_sel, rf_wr, rf_dst_sel}
    logic [15:0] obs;
    assign obs = {pc_load, pc_load_if_eq, addr_sel_data, mem_rd, mem_wr,
                  instr_load, wb_sel_mem, pc_src, alu_mode, alu_b_sel,
                  alu_a_sel, rf_wr, rf_dst_sel};

    localparam logic [15:0] W_FETCH  = 16'b1001010_00_00_01_000;
    localparam logic [15:0] W_DECODE = 16'b0000000_00_00_11_000;
    localparam logic [15:0] W_ADDR   = 16'b0000000_00_00_10_100;
    localparam logic [15:0] W_MEMRD  = 16'b0011000_00_00_00_000;
    localparam logic [15:0] W_LDWB   = 16'b0000001_00_00_00_010;
    localparam logic [15:0] W_MEMWR  = 16'b0010100_00_00_00_000;
    localparam logic [15:0] W_EXEC   = 16'b0000000_00_10_00_100;
    localparam logic [15:0] W_ALUWB  = 16'b0000000_00_00_00_011;
    localparam logic [15:0] W_BRANCH = 16'b0100000_01_01_00_100;
    localparam logic [15:0] W_JUMP   = 16'b1000000_10_00_00_000;

    // {opcode, length, step words 0..4}
    localparam int NV = 7;
    localparam logic [88:0] VEC [NV] = '{
        {6'b100011, 3'd5, W_FETCH, W_DECODE, W_ADDR,   W_MEMRD, W_LDWB},
        {6'b101011, 3'd4, W_FETCH, W_DECODE, W_ADDR,   W_MEMWR, W_FETCH},
        {6'b000000, 3'd4, W_FETCH, W_DECODE, W_EXEC,   W_ALUWB, W_FETCH},
        {6'b000100, 3'd3, W_FETCH, W_DECODE, W_BRANCH, W_FETCH, W_FETCH},
        {6'b000010, 3'd3, W_FETCH, W_DECODE, W_JUMP,   W_FETCH, W_FETCH},
        {6'b000001, 3'd2, W_FETCH, W_DECODE, W_FETCH,  W_FETCH, W_FETCH},
        {6'b111111, 3'd2, W_FETCH, W_DECODE, W_FETCH,  W_FETCH, W_FETCH}
    };

    function automatic string tag_of(int v, int k);
        if (k == 0) return "R2";
        if (k == 1) return "R3";
        case (v)
            0: return (k == 2) ? "R5" : "R6";
            1: return (k == 2) ? "R5" : "R7";
            2: return "R8";
            3: return "R9";
            4: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", obs, W_FETCH);

        // table walk: each instruction from fetch back to fetch
        for (int v = 0; v < NV; v++) begin
            int len;
            opcode = VEC[v][88:83];
            len    = int'(VEC[v][82:80]);
            for (int k = 0; k < len; k++) begin
                check(tag_of(v, k), obs, VEC[v][79-16*k -: 16]);
                step();
            end
            check((v >= 5) ? "R12 length" : "R11 length", obs, W_FETCH);
        end

        // R13: opcode change mid-cycle leaves outputs alone
        opcode = 6'b100011;
        #1 opcode = 6'b000010;
        #0.5 check("R13 fetch ignores opcode", obs, W_FETCH);
        step();
        opcode = 6'b100011;
        #1 opcode = 6'b000100;
        #0.5 check("R13 decode ignores opcode", obs, W_DECODE);
        step();
        check("R4 edge value picks branch", obs, W_BRANCH);
        step();

        // R5: address step splits on opcode seen at its own edge
        opcode = 6'b100011;
        step();
        step();
        check("R5 address step", obs, W_ADDR);
        opcode = 6'b101011;
        step();
        check("R5 store picked in address step", obs, W_MEMWR);
        step();
        check("R7 store returns", obs, W_FETCH);

        // R1: reset in the middle of a load
        opcode = 6'b100011;
        step(); step(); step();
        check("R6 memory read before reset", obs, W_MEMRD);
        rst = 1'b1;
        step();
        check("R1 mid-instruction reset", obs, W_FETCH);
        step();
        check("R1 held in reset", obs, W_FETCH);
        rst = 1'b0;
        step();
        check("R2 leaves fetch after reset", obs, W_DECODE);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog expired: got hang expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule